// File: doc/BRIEF.md
# Interval-Timed Converter Sampling Sequencer

This block drives a parallel 12-bit sampling converter from the host side. Its handshake has an active-low conversion start, a BUSY status line, and active-low chip select and read strobes. An interval timer, counted in system clocks, sets the sampling rate. On each timer tick the block pulls the start line low for a programmed number of cycles. It then waits for the converter to report busy and then done.

When done is reported, the block runs a read cycle with chip select wrapped around the read strobe. It captures the 12-bit result and forwards it as a 16-bit left-justified word on a valid/ready stream. A one-cycle end-of-conversion pulse marks each completed conversion.

The block also enforces the converter's timing rules:
- No start is issued while the converter is busy.
- Reading waits a fixed gap after BUSY returns high.
- A minimum acquisition interval must pass after BUSY returns high before the next start.
- The programmed period is never allowed below a legal floor.

The BUSY input is asynchronous and passes through a two-flop synchroniser. If the stream consumer stalls, a newer sample replaces the held one and an overrun flag is raised.

Top module: `adc_sample_ctrl`

## Requirements
- R1: While enabled, and with the period long enough for a full conversion and read, start falling edges are spaced exactly max(cfg_period, MIN_PERIOD) clock cycles apart.
- R2: The start line stays low for exactly max(cfg_start_low, 1) cycles per conversion.
- R3: The start line never falls while the converter's BUSY input is low.
- R4: At least ACQ_CYC cycles separate a BUSY rising edge from the next start falling edge.
- R5: eoc_irq is a single-cycle pulse, issued once for every BUSY rising edge.
- R6: The read strobe falls only while BUSY is high, and at least RD_GAP + 2 cycles after BUSY rises (the synchroniser costs two of these).
- R7: Chip select falls at least one cycle before the read strobe falls, and is still low in the cycle the read strobe rises.
- R8: The read strobe stays low for exactly max(cfg_rd_low, 1) cycles.
- R9: The stream word is the captured 12-bit code in bits 15:4, with bits 3:0 equal to 0000.
- R10: m_valid and m_data hold steady until m_ready accepts the word, and with m_ready high every conversion is delivered exactly once.
- R11: A capture that arrives while an unaccepted word is held replaces that word with the newer code and sets overrun. overrun clears on the next accepted transfer.
- R12: With enable low no start is issued, and a pending timer tick is dropped.
- R13: While reset is active the start, chip select and read outputs are high, and m_valid, eoc_irq and overrun are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the interval timer |
| cfg_period | input | 16 | Sampling period in clocks (floored at MIN_PERIOD) |
| cfg_start_low | input | 8 | Start pulse low width in clocks (0 treated as 1) |
| cfg_rd_low | input | 8 | Read strobe low width in clocks (0 treated as 1) |
| adc_busy | input | 1 | Converter status, low while converting (asynchronous) |
| adc_data | input | 12 | Converter parallel result |
| adc_convst_n | output | 1 | Conversion start, active low |
| adc_cs_n | output | 1 | Chip select, active low |
| adc_rd_n | output | 1 | Read strobe, active low |
| m_valid | output | 1 | Stream word valid |
| m_ready | input | 1 | Stream consumer ready |
| m_data | output | 16 | Left-justified sample |
| eoc_irq | output | 1 | One-cycle end-of-conversion pulse |
| overrun | output | 1 | Set when a held sample was replaced |

## Verification
The bound assertions are evaluated on every clock. They check the converter-side ordering: no start while synchronised BUSY is low, the acquisition and read gaps measured from the BUSY rise, read kept inside chip select, and the single-cycle interrupt. On the stream side they check zero padding, a held word staying stable, and overrun raised on replacement. The exact cycle counts of the period, start width and read width, the clamping of zero and sub-floor settings, and the code values delivered in order can only be shown by the bench. It sweeps periods, start widths and read widths against a behavioural converter model with a known code sequence. The same applies to disable behaviour and to clearing overrun.

// File: rtl/adc_sc_pkg.sv
package adc_sc_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_START,
    SQ_WAIT_LO,
    SQ_WAIT_HI,
    SQ_GAP,
    SQ_CS_SETUP,
    SQ_READ,
    SQ_CS_HOLD
  } seq_state_t;
endpackage

// File: rtl/adc_sc_busy_sync.sv
module adc_sc_busy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_async,
  output logic busy_s,
  output logic busy_rise
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  // reset to the idle (high) level so release creates no false edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      last_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], busy_async};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign busy_s    = chain_q[STAGES-1];
  assign busy_rise = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/adc_sc_timer.sv
module adc_sc_timer #(
  parameter int PER_W      = 16,
  parameter int MIN_PERIOD = 134
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [PER_W-1:0] cfg_period,
  input  logic             start_ack,
  output logic             pending
);
  localparam logic [PER_W-1:0] FLOOR = PER_W'(MIN_PERIOD);

  logic [PER_W-1:0] cnt_q, cnt_n, eff_period;
  logic             pend_q, pend_n, tick;

  assign eff_period = (cfg_period < FLOOR) ? FLOOR : cfg_period;
  assign tick       = enable && (cnt_q == '0);

  always_comb begin
    cnt_n  = cnt_q;
    pend_n = pend_q;
    if (!enable) begin
      cnt_n  = '0;
      pend_n = 1'b0;
    end else begin
      cnt_n = tick ? eff_period - 1'b1 : cnt_q - 1'b1;
      if (tick)           pend_n = 1'b1;
      else if (start_ack) pend_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      pend_q <= pend_n;
    end
  end

  assign pending = pend_q;
endmodule

// File: rtl/adc_sc_seq.sv
module adc_sc_seq
  import adc_sc_pkg::*;
#(
  parameter int PW_W    = 8,
  parameter int ACQ_CYC = 34,
  parameter int RD_GAP  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pending,
  input  logic            busy_s,
  input  logic            busy_rise,
  input  logic [PW_W-1:0] cfg_start_low,
  input  logic [PW_W-1:0] cfg_rd_low,
  output logic            start_ack,
  output logic            capture,
  output logic            convst_n,
  output logic            cs_n,
  output logic            rd_n
);
  localparam int ACQ_W = $clog2(ACQ_CYC + 2);
  localparam logic [ACQ_W-1:0] ACQ_MAX = ACQ_W'(ACQ_CYC);
  localparam logic [PW_W-1:0]  GAP_LD  = PW_W'(RD_GAP - 1);

  seq_state_t       st_q, st_n;
  logic [PW_W-1:0]  cnt_q, cnt_n, eff_start, eff_rd;
  logic [ACQ_W-1:0] acq_q, acq_n;
  logic             acq_ok;

  assign eff_start = (cfg_start_low == '0) ? PW_W'(1) : cfg_start_low;
  assign eff_rd    = (cfg_rd_low == '0) ? PW_W'(1) : cfg_rd_low;
  assign acq_ok    = (acq_q >= ACQ_MAX);

  always_comb begin
    st_n      = st_q;
    cnt_n     = cnt_q;
    start_ack = 1'b0;
    capture   = 1'b0;
    unique case (st_q)
      SQ_IDLE: if (pending && busy_s && acq_ok) begin
        st_n      = SQ_START;
        cnt_n     = eff_start - 1'b1;
        start_ack = 1'b1;
      end
      SQ_START: begin
        if (cnt_q == '0) st_n = SQ_WAIT_LO;
        else             cnt_n = cnt_q - 1'b1;
      end
      SQ_WAIT_LO: if (!busy_s) st_n = SQ_WAIT_HI;
      SQ_WAIT_HI: if (busy_rise) begin
        st_n  = SQ_GAP;
        cnt_n = GAP_LD;
      end
      SQ_GAP: begin
        if (cnt_q == '0) st_n = SQ_CS_SETUP;
        else             cnt_n = cnt_q - 1'b1;
      end
      SQ_CS_SETUP: begin
        st_n  = SQ_READ;
        cnt_n = eff_rd - 1'b1;
      end
      SQ_READ: begin
        if (cnt_q == '0) begin
          st_n    = SQ_CS_HOLD;
          capture = 1'b1;
        end else begin
          cnt_n = cnt_q - 1'b1;
        end
      end
      SQ_CS_HOLD: st_n = SQ_IDLE;
      default:    st_n = SQ_IDLE;
    endcase
  end

  always_comb begin
    acq_n = acq_q;
    if (busy_rise)   acq_n = '0;
    else if (!acq_ok) acq_n = acq_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      cnt_q <= '0;
      acq_q <= ACQ_MAX;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      acq_q <= acq_n;
    end
  end

  assign convst_n = (st_q != SQ_START);
  assign rd_n     = (st_q != SQ_READ);
  assign cs_n     = !((st_q == SQ_CS_SETUP) || (st_q == SQ_READ) || (st_q == SQ_CS_HOLD));
endmodule

// File: rtl/adc_sc_out.sv
module adc_sc_out #(
  parameter int CODE_W = 12,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [CODE_W-1:0] code,
  input  logic              m_ready,
  output logic              m_valid,
  output logic [WORD_W-1:0] m_data,
  output logic              overrun
);
  localparam int PAD_W = WORD_W - CODE_W;

  logic              vld_q, vld_n, ovr_q, ovr_n, load;
  logic [WORD_W-1:0] dat_q, dat_n;

  assign load = capture;

  always_comb begin
    vld_n = vld_q;
    ovr_n = ovr_q;
    dat_n = dat_q;
    if (capture) begin
      dat_n = {code, {PAD_W{1'b0}}};
      vld_n = 1'b1;
      if (vld_q && !m_ready)     ovr_n = 1'b1;
      else if (vld_q && m_ready) ovr_n = 1'b0;
    end else if (vld_q && m_ready) begin
      vld_n = 1'b0;
      ovr_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      vld_q <= vld_n;
      ovr_q <= ovr_n;
    end
  end

  // data register needs no reset; it is loaded only on capture
  always_ff @(posedge clk) begin
    if (load) dat_q <= dat_n;
  end

  assign m_valid = vld_q;
  assign m_data  = dat_q;
  assign overrun = ovr_q;
endmodule

// File: rtl/adc_sample_ctrl.sv
module adc_sample_ctrl #(
  parameter int CODE_W      = 12,
  parameter int WORD_W      = 16,
  parameter int PER_W       = 16,
  parameter int PW_W        = 8,
  parameter int MIN_PERIOD  = 134,
  parameter int ACQ_CYC     = 34,
  parameter int RD_GAP      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [PER_W-1:0]  cfg_period,
  input  logic [PW_W-1:0]   cfg_start_low,
  input  logic [PW_W-1:0]   cfg_rd_low,
  input  logic              adc_busy,
  input  logic [CODE_W-1:0] adc_data,
  output logic              adc_convst_n,
  output logic              adc_cs_n,
  output logic              adc_rd_n,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [WORD_W-1:0] m_data,
  output logic              eoc_irq,
  output logic              overrun
);
  logic busy_s, busy_rise, pending, start_ack, capture;

  adc_sc_busy_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .busy_async(adc_busy),
    .busy_s(busy_s), .busy_rise(busy_rise)
  );

  adc_sc_timer #(.PER_W(PER_W), .MIN_PERIOD(MIN_PERIOD)) u_timer (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_period(cfg_period),
    .start_ack(start_ack), .pending(pending)
  );

  adc_sc_seq #(.PW_W(PW_W), .ACQ_CYC(ACQ_CYC), .RD_GAP(RD_GAP)) u_seq (
    .clk(clk), .rst_n(rst_n), .pending(pending), .busy_s(busy_s),
    .busy_rise(busy_rise), .cfg_start_low(cfg_start_low),
    .cfg_rd_low(cfg_rd_low), .start_ack(start_ack), .capture(capture),
    .convst_n(adc_convst_n), .cs_n(adc_cs_n), .rd_n(adc_rd_n)
  );

  adc_sc_out #(.CODE_W(CODE_W), .WORD_W(WORD_W)) u_out (
    .clk(clk), .rst_n(rst_n), .capture(capture), .code(adc_data),
    .m_ready(m_ready), .m_valid(m_valid), .m_data(m_data), .overrun(overrun)
  );

  assign eoc_irq = busy_rise;
endmodule

// File: rtl/adc_sample_ctrl_chk.sv
module adc_sample_ctrl_chk #(
  parameter int CODE_W  = 12,
  parameter int WORD_W  = 16,
  parameter int ACQ_CYC = 34,
  parameter int RD_GAP  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              convst_n,
  input logic              cs_n,
  input logic              rd_n,
  input logic              busy_s,
  input logic              busy_rise,
  input logic              capture,
  input logic              m_valid,
  input logic              m_ready,
  input logic [WORD_W-1:0] m_data,
  input logic              eoc_irq,
  input logic              overrun
);
  localparam int PAD_W = WORD_W - CODE_W;
  localparam int CW    = $clog2(ACQ_CYC + RD_GAP + 2) + 1;

  logic [CW-1:0] acq_c, gap_c;

  // cycles elapsed since the last synchronised BUSY rise, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acq_c <= CW'(ACQ_CYC);
      gap_c <= '0;
    end else begin
      if (busy_rise)                acq_c <= '0;
      else if (acq_c < CW'(ACQ_CYC)) acq_c <= acq_c + 1'b1;
      if (busy_rise)                gap_c <= '0;
      else if (gap_c < CW'(RD_GAP))  gap_c <= gap_c + 1'b1;
    end
  end

  AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(convst_n) |-> busy_s); // R3
  AST_ACQ_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(convst_n) |-> (acq_c >= CW'(ACQ_CYC))); // R4
  AST_EOC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_irq |=> !eoc_irq); // R5
  AST_READ_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n) |-> (busy_s && gap_c >= CW'(RD_GAP))); // R6
  AST_RD_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !cs_n); // R7
  AST_CS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_n) |-> !cs_n); // R7
  AST_ZERO_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> (m_data[PAD_W-1:0] == '0)); // R9
  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready && !capture) |=> (m_valid && $stable(m_data))); // R10
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && m_valid && !m_ready) |=> overrun); // R11
endmodule

bind adc_sample_ctrl adc_sample_ctrl_chk #(
  .CODE_W(CODE_W), .WORD_W(WORD_W), .ACQ_CYC(ACQ_CYC), .RD_GAP(RD_GAP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .convst_n(adc_convst_n), .cs_n(adc_cs_n),
  .rd_n(adc_rd_n), .busy_s(busy_s), .busy_rise(busy_rise), .capture(capture),
  .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .eoc_irq(eoc_irq),
  .overrun(overrun)
);

// File: tb/adc_sample_ctrl_tb.sv
`timescale 1ns/1ps
module adc_sample_ctrl_tb;
  localparam int MINP = 40;
  localparam int ACQ  = 6;
  localparam int GAP  = 2;
  localparam int CONV = 12;
  localparam logic [11:0] SEED = 12'h0A5;
  localparam logic [11:0] STEP = 12'h3C7;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, m_ready = 1'b0;
  logic [15:0] cfg_period = 16'd0;
  logic [7:0]  cfg_start_low = 8'd0, cfg_rd_low = 8'd0;
  logic        adc_busy = 1'b1;
  logic [11:0] adc_data;
  logic adc_convst_n, adc_cs_n, adc_rd_n, m_valid, eoc_irq, overrun;
  logic [15:0] m_data;

  always #2.5 clk = ~clk;

  adc_sample_ctrl #(.MIN_PERIOD(MINP), .ACQ_CYC(ACQ), .RD_GAP(GAP)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_period(cfg_period),
    .cfg_start_low(cfg_start_low), .cfg_rd_low(cfg_rd_low),
    .adc_busy(adc_busy), .adc_data(adc_data), .adc_convst_n(adc_convst_n),
    .adc_cs_n(adc_cs_n), .adc_rd_n(adc_rd_n), .m_valid(m_valid),
    .m_ready(m_ready), .m_data(m_data), .eoc_irq(eoc_irq), .overrun(overrun)
  );

  function automatic logic [11:0] code_of(input int n);
    code_of = SEED + 12'(n) * STEP;
  endfunction

  // behavioural converter
  int  mdl_n = 0, mcnt = 0;
  logic cv_d = 1'b1;
  always @(posedge clk) begin
    cv_d <= adc_convst_n;
    if (adc_convst_n && !cv_d) begin
      adc_busy <= 1'b0;
      mcnt     <= CONV;
    end else if (!adc_busy) begin
      if (mcnt == 1) begin
        adc_busy <= 1'b1;
        mdl_n    <= mdl_n + 1;
      end
      mcnt <= mcnt - 1;
    end
  end
  assign adc_data = (!adc_cs_n && !adc_rd_n && adc_busy) ? code_of(mdl_n - 1) : 12'hBAD;

  int nchk = 0, nfail = 0;
  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // monitor, sampling on the falling edge
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int exp_per = MINP, exp_sw = 1, exp_rw = 1;
  int conv_done = 0, acc_cnt = 0, eoc_cnt = 0, cfall_cnt = 0;
  longint t_cfall = 0, t_rfall = 0, t_brise = 0;
  bit have_prev = 0, seen_rise = 0;
  logic p_cv = 1'b1, p_cs = 1'b1, p_rd = 1'b1, p_busy = 1'b1, p_eoc = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!enable) have_prev = 0;
      if (adc_busy && !p_busy) begin
        t_brise = cyc; seen_rise = 1; conv_done++;
      end
      if (!adc_convst_n && p_cv) begin
        chk(adc_busy == 1'b1, "R3 start while busy low", adc_busy, 1);
        if (have_prev) chk(cyc - t_cfall == exp_per, "R1 start spacing", cyc - t_cfall, exp_per);
        if (seen_rise) chk(cyc - t_brise >= ACQ, "R4 acquisition gap", cyc - t_brise, ACQ);
        t_cfall = cyc; have_prev = 1; cfall_cnt++;
      end
      if (adc_convst_n && !p_cv)
        chk(cyc - t_cfall == exp_sw, "R2 start low width", cyc - t_cfall, exp_sw);
      if (!adc_rd_n && p_rd) begin
        chk(p_cs == 1'b0, "R7 cs setup", p_cs, 0);
        chk(adc_busy == 1'b1, "R6 read while busy", adc_busy, 1);
        chk(cyc - t_brise >= GAP + 2, "R6 read gap", cyc - t_brise, GAP + 2);
        t_rfall = cyc;
      end
      if (adc_rd_n && !p_rd) begin
        chk(adc_cs_n == 1'b0, "R7 cs hold", adc_cs_n, 0);
        chk(cyc - t_rfall == exp_rw, "R8 read low width", cyc - t_rfall, exp_rw);
      end
      if (eoc_irq) begin
        eoc_cnt++;
        if (p_eoc) chk(0, "R5 eoc pulse width", 2, 1);
      end
      if (m_valid && m_ready) begin
        chk(m_data == {code_of(conv_done - 1), 4'b0000}, "R9 sample word",
            m_data, {code_of(conv_done - 1), 4'b0000});
        acc_cnt++;
      end
    end
    p_cv = adc_convst_n; p_cs = adc_cs_n; p_rd = adc_rd_n;
    p_busy = adc_busy; p_eoc = eoc_irq;
  end

  task automatic run(input int p, input int s, input int r);
    int c0, a0, e0;
    @(negedge clk);
    cfg_period = 16'(p); cfg_start_low = 8'(s); cfg_rd_low = 8'(r);
    exp_per = (p < MINP) ? MINP : p;
    exp_sw  = (s == 0) ? 1 : s;
    exp_rw  = (r == 0) ? 1 : r;
    m_ready = 1'b1;
    c0 = conv_done; a0 = acc_cnt; e0 = eoc_cnt;
    enable = 1'b1;
    while (acc_cnt < a0 + 4) @(negedge clk);
    enable = 1'b0;
    repeat (60) @(negedge clk);
    chk(acc_cnt - a0 == conv_done - c0, "R10 each conversion delivered once", acc_cnt - a0, conv_done - c0);
    chk(eoc_cnt - e0 == conv_done - c0, "R5 one eoc per conversion", eoc_cnt - e0, conv_done - c0);
    chk(!overrun, "R11 no overrun with ready high", overrun, 0);
  endtask

  bit done = 0;
  initial begin
    int c0, f0;
    repeat (4) @(negedge clk);
    chk(adc_convst_n && adc_cs_n && adc_rd_n, "R13 strobes high in reset",
        {adc_convst_n, adc_cs_n, adc_rd_n}, 3'b111);
    chk(!m_valid && !eoc_irq && !overrun, "R13 flags low in reset",
        {m_valid, eoc_irq, overrun}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // sweep: periods (0 and 20 clamp to the floor), start widths, read widths
    foreach (cfg_period_list[i])
      for (int s = 0; s < 4; s++)
        for (int r = 0; r < 5; r++)
          run(cfg_period_list[i], s, r);

    // R12: disabled block issues no start
    f0 = cfall_cnt;
    cfg_period = 16'd41;
    repeat (200) @(negedge clk);
    chk(cfall_cnt == f0 && adc_convst_n, "R12 no start while disabled", cfall_cnt - f0, 0);

    // R10/R11: stalled consumer
    m_ready = 1'b0; cfg_start_low = 8'd2; cfg_rd_low = 8'd2; cfg_period = 16'd45;
    exp_per = 45; exp_sw = 2; exp_rw = 2;
    c0 = conv_done;
    enable = 1'b1;
    while (conv_done < c0 + 1) @(negedge clk);
    repeat (30) @(negedge clk);
    chk(m_valid && !overrun, "R10 word held without overrun", {m_valid, overrun}, 2'b10);
    chk(m_data == {code_of(conv_done - 1), 4'b0000}, "R10 held word value",
        m_data, {code_of(conv_done - 1), 4'b0000});
    while (conv_done < c0 + 3) @(negedge clk);
    repeat (30) @(negedge clk);
    enable = 1'b0;
    chk(m_valid && overrun, "R11 overrun set", {m_valid, overrun}, 2'b11);
    chk(m_data == {code_of(conv_done - 1), 4'b0000}, "R11 newest word kept",
        m_data, {code_of(conv_done - 1), 4'b0000});
    repeat (60) @(negedge clk);
    m_ready = 1'b1;
    @(negedge clk);
    chk(!m_valid && !overrun, "R11 cleared by transfer", {m_valid, overrun}, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  int cfg_period_list[4] = '{0, 20, 44, 57};

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule